// File: doc/BRIEF.md
# End-Around-Carry Modulo (2^b - 1) Adder

This block adds two b-bit operands in one's-complement arithmetic, producing a b-bit result that is congruent to their sum modulo 2^b - 1. It is purely combinational. The carry out of the plain binary sum is the only signal that decides whether the result is incremented by one. No comparison against the modulus is made.

As a consequence, zero can leave the block in either of its two encodings: all zeros or all ones. A downstream consumer that needs a unique zero can enable an optional clean-up stage. That stage rewrites an all-ones result as all zeros.

Two internal structures are offered behind one parameter, and both give the same result bits:
- **Dual-sum:** forms the sum and the sum plus one side by side, then picks one of them with the carry.
- **Carry-feedback:** adds the carry back into the truncated sum and needs no multiplexer.

Top module: `endAroundAdder`

## Requirements
- R1: For every operand pair, the integer value of `sumOut` modulo 2^WIDTH - 1 equals (opA + opB) modulo 2^WIDTH - 1.
- R2: With CANON = 0, when opA + opB < 2^WIDTH, `sumOut` equals opA + opB.
- R3: With CANON = 0, when opA + opB >= 2^WIDTH, `sumOut` equals (opA + opB + 1) mod 2^WIDTH. The increment is selected by the carry out of opA + opB alone.
- R4: With CANON = 0, operands whose sum is exactly 2^WIDTH - 1 produce the all-ones pattern. Because no comparison with the modulus is made, this is the second encoding of zero.
- R5: With CANON = 1, an all-ones result is replaced by all zeros. Every other result is the same as with CANON = 0, so `sumOut` is never all ones.
- R6: ARCH = 0 (dual-sum with multiplexer) and ARCH = 1 (carry fed back into the sum) give bit-identical `sumOut` for every operand pair, under the same CANON value.
- R7: When both operands are all ones, `sumOut` is all ones with CANON = 0 and all zeros with CANON = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| sumOut | output | WIDTH | One's-complement sum, congruent to opA + opB modulo 2^WIDTH - 1 |

## Verification
The bench builds four copies at WIDTH = 7, one for each combination of ARCH in {0, 1} and CANON in {0, 1}. It drives all 16,384 operand pairs through them. At this width the sweep is exhaustive, so every carry and no-carry case is reached. So are the exact-modulus sums that yield the all-ones zero and the double all-ones corner. Both structures are compared bit for bit against each other and against an integer model, with and without the zero clean-up.

// File: rtl/eacPkg.sv
package eacPkg;
  // structure selectors for the ARCH parameter
  localparam int ARCH_DUAL = 0;  // two sums in parallel, carry-driven multiplexer
  localparam int ARCH_FEED = 1;  // carry added back into the truncated sum

  // strobes from the carry decision logic to the datapath
  typedef struct packed {
    logic incr;         // carry out of opA + opB: result takes +1
    logic allOnesHint;  // final pre-cleanup result will be all ones
  } eacStrobeT;
endpackage

// File: rtl/eacControl.sv
module eacControl
  import eacPkg::*;
#(
  parameter int WIDTH = 7
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output eacStrobeT        strobe
);
  localparam int WIDE = WIDTH + 1;

  logic [WIDE-1:0] wideSum;
  logic            carryOut;
  logic            lowAllOnes;
  logic            bothFull;

  always_comb begin
    wideSum    = {1'b0, opA} + {1'b0, opB};
    carryOut   = wideSum[WIDTH];
    lowAllOnes = &wideSum[WIDTH-1:0];
    bothFull   = (&opA) & (&opB);
    strobe.incr        = carryOut;
    // no carry: result is the raw sum; with carry only all-ones inputs wrap to all ones
    strobe.allOnesHint = (~carryOut & lowAllOnes) | bothFull;
  end

  always_comb begin
    if (!$isunknown({opA, opB})) begin
      AST_INCR_ON_CARRY: assert (strobe.incr == ((int'(opA) + int'(opB)) >= (2 ** WIDTH))); // R3
    end
  end
endmodule

// File: rtl/eacDatapath.sv
module eacDatapath
  import eacPkg::*;
#(
  parameter int WIDTH = 7,
  parameter int ARCH  = ARCH_DUAL,
  parameter int CANON = 0
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  eacStrobeT        strobe,
  output logic [WIDTH-1:0] result
);
  localparam int MODULUS = (2 ** WIDTH) - 1;
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] chosen;

  generate
    if (ARCH == ARCH_FEED) begin : g_feed
      logic [WIDTH-1:0] partial;
      always_comb begin
        partial = opA + opB;
        chosen  = partial + {{(WIDTH-1){1'b0}}, strobe.incr};
      end
    end else begin : g_dual
      logic [WIDTH-1:0] sumPlain;
      logic [WIDTH-1:0] sumBump;
      always_comb begin
        sumPlain = opA + opB;
        sumBump  = opA + opB + ONE;
        chosen   = strobe.incr ? sumBump : sumPlain;
      end
    end
  endgenerate

  generate
    if (CANON != 0) begin : g_canon
      always_comb result = strobe.allOnesHint ? '0 : chosen;
    end else begin : g_raw
      always_comb result = chosen;
    end
  endgenerate

  always_comb begin
    if (!$isunknown({opA, opB})) begin
      AST_CONGRUENT: assert ((int'(result) % MODULUS) == ((int'(opA) + int'(opB)) % MODULUS)); // R1
      AST_HINT_MATCH: assert ((&chosen) == strobe.allOnesHint); // R7
      if (CANON != 0) begin
        AST_NO_ONES_OUT: assert (!(&result)); // R5
      end
      if (!strobe.incr && CANON == 0) begin
        AST_PLAIN_PASS: assert (int'(result) == (int'(opA) + int'(opB))); // R2
      end
    end
  end
endmodule

// File: rtl/endAroundAdder.sv
module endAroundAdder
  import eacPkg::*;
#(
  parameter int WIDTH = 7,
  parameter int ARCH  = ARCH_DUAL,
  parameter int CANON = 0
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sumOut
);
  eacStrobeT strobe;

  eacControl #(.WIDTH(WIDTH)) uCtrl (
    .opA   (opA),
    .opB   (opB),
    .strobe(strobe)
  );

  eacDatapath #(.WIDTH(WIDTH), .ARCH(ARCH), .CANON(CANON)) uPath (
    .opA   (opA),
    .opB   (opB),
    .strobe(strobe),
    .result(sumOut)
  );
endmodule

// File: tb/sim_endAroundAdder.sv
module sim_endAroundAdder;
  localparam int W   = 7;
  localparam int TOP = 2 ** W;
  localparam int MOD = TOP - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [W-1:0] outDualRaw, outFeedRaw, outDualCan, outFeedCan;
  int total = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;
  int expQ[$];

  always #5 clk = ~clk;

  endAroundAdder #(.WIDTH(W), .ARCH(0), .CANON(0)) u0 (.opA(opA), .opB(opB), .sumOut(outDualRaw));
  endAroundAdder #(.WIDTH(W), .ARCH(1), .CANON(0)) u1 (.opA(opA), .opB(opB), .sumOut(outFeedRaw));
  endAroundAdder #(.WIDTH(W), .ARCH(0), .CANON(1)) u2 (.opA(opA), .opB(opB), .sumOut(outDualCan));
  endAroundAdder #(.WIDTH(W), .ARCH(1), .CANON(1)) u3 (.opA(opA), .opB(opB), .sumOut(outFeedCan));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", tag, opA, opB, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: zero operands give zero on every copy (R2)
    chk("R2 reset u0", int'(outDualRaw), 0);
    chk("R2 reset u1", int'(outFeedRaw), 0);
    chk("R5 reset u2", int'(outDualCan), 0);
    chk("R5 reset u3", int'(outFeedCan), 0);
    for (int ia = 0; ia < TOP; ia++) begin
      for (int ib = 0; ib < TOP; ib++) begin
        @(posedge clk);
        #1;
        opA = W'(ia);
        opB = W'(ib);
        begin
          int s;
          int raw;
          s   = ia + ib;
          raw = (s >= TOP) ? ((s + 1) % TOP) : s;
          expQ.push_back(raw);
        end
        @(negedge clk);
        begin
          int raw;
          int can;
          int s;
          s   = ia + ib;
          raw = expQ.pop_front();
          can = (raw == MOD) ? 0 : raw;
          if (ia == MOD && ib == MOD) begin
            chk("R7 raw", int'(outDualRaw), MOD);
            chk("R7 canon", int'(outDualCan), 0);
          end else if (s == MOD) begin
            chk("R4 double-zero", int'(outDualRaw), MOD);
          end else if (s >= TOP) begin
            chk("R3 carry", int'(outDualRaw), raw);
          end else begin
            chk("R2 no-carry", int'(outDualRaw), raw);
          end
          chk("R1 congruence", int'(outDualRaw) % MOD, s % MOD);
          chk("R6 feed vs dual raw", int'(outFeedRaw), int'(outDualRaw));
          chk("R5 canon dual", int'(outDualCan), can);
          chk("R5 canon feed", int'(outFeedCan), can);
          chk("R6 feed vs dual canon", int'(outFeedCan), int'(outDualCan));
        end
      end
    end
    finishRun();
  end
endmodule